// File: doc/BRIEF.md
# Double-Precision Sign-Flip Exponent Scaler

This block takes a 64-bit IEEE 754 binary64 bit pattern and negates it. It also multiplies the value by a power of two 2^x, and x comes from the operand itself. The five lowest bits of the biased exponent form a signed-digit number. A set bit at position i counts as +2^i and a clear bit counts as -2^i. So x = 2*v - 31, where v is the plain unsigned value of those bits, and x is always an odd number from -31 to +31.

Negating a value and scaling it by a power of two changes only the sign bit and the exponent. The block therefore uses no multiplier. It flips the sign bit, adds x to the 11-bit exponent field and passes the 52-bit mantissa through unchanged.

Callers must supply normal operands whose exponent stays inside the normal range after the add. Zeros, denormals, infinities and NaNs are not accepted. With these operands the result is always a normal number and never a NaN.

A parameter selects the output timing. The block can be purely combinational, or it can have one output register stage. A valid strobe goes with the data in both cases.

Top module: `fp_negscale`

## Requirements
- R1: The output sign bit (bit 63) is the inverse of the input sign bit.
- R2: The output mantissa field (bits 51:0) equals the input mantissa field.
- R3: The output exponent field (bits 62:52) equals the input exponent field plus x. Here x = 2*v - 31 and v is the unsigned value of input bits 56:52.
- R4: Read as a real number, the output equals the negated input multiplied by 2^x.
- R5: For every one of the 32 patterns of input bits 56:52, x is odd and lies in [-31, +31].
- R6: With OUT_REG=1, out_vld is high exactly one clock cycle after a cycle in which in_vld was high, and low otherwise. out_bits carries the result for the operand accepted in that earlier cycle.
- R7: While rst_n is low, out_vld is low.
- R8: With OUT_REG=0, out_vld equals in_vld and out_bits shows the result in the same cycle the input is presented.
- R9: With OUT_REG=1, out_bits holds its value across cycles in which in_vld is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_vld | input | 1 | Input operand valid |
| in_bits | input | 64 | Input binary64 bit pattern |
| out_vld | output | 1 | Result valid |
| out_bits | output | 64 | Result binary64 bit pattern |

## Verification
The bench builds two copies of the block that share the same inputs: `u_dut` with OUT_REG=1 and `u_dut_c` with OUT_REG=0. This covers both the one-cycle timing and the same-cycle timing, including the strobe and hold behaviour of the register stage.

Both copies receive all 32 digit patterns in the exponent. They also receive random signs, mantissas and exponents, with the exponents restricted so the result stays in range.

Each result is compared field by field. It is also compared as a real number against the negated input times 2^x, where x is summed digit by digit in the bench.

// File: rtl/fp_negscale.sv
module fp_negscale #(
  parameter int EXP_W   = 11,
  parameter int MAN_W   = 52,
  parameter int SEL_W   = 5,
  parameter bit OUT_REG = 1'b1,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] in_bits,
  output logic         out_vld,
  output logic [W-1:0] out_bits
);

  logic                 sgn;
  logic [EXP_W-1:0]     exp_in;
  logic [EXP_W-1:0]     exp_out;
  logic [MAN_W-1:0]     man;
  logic [SEL_W-1:0]     sel;
  logic [SEL_W:0]       scale;
  logic [W-1:0]         res;

  assign {sgn, exp_in, man} = in_bits;
  assign sel = exp_in[SEL_W-1:0];

  // signed-digit value 2v+1-2^SEL_W: invert the MSB and append a one
  assign scale   = {~sel[SEL_W-1], sel[SEL_W-2:0], 1'b1};
  assign exp_out = exp_in + {{(EXP_W-SEL_W-1){scale[SEL_W]}}, scale};
  assign res     = {~sgn, exp_out, man};

  generate
    if (OUT_REG) begin : g_reg
      logic         vld_q;
      logic [W-1:0] res_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          res_q <= '0;
        end else begin
          vld_q <= in_vld;
          if (in_vld) res_q <= res;
        end
      end
      assign out_vld  = vld_q;
      assign out_bits = res_q;
    end else begin : g_comb
      assign out_vld  = in_vld;
      assign out_bits = res;
    end
  endgenerate

endmodule

// File: rtl/fp_negscale_chk.sv
module fp_negscale_chk #(
  parameter int EXP_W   = 11,
  parameter int MAN_W   = 52,
  parameter int SEL_W   = 5,
  parameter bit OUT_REG = 1'b1,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_vld,
  input logic [W-1:0] in_bits,
  input logic         out_vld,
  input logic [W-1:0] out_bits
);

  logic [W-1:0] cap_q;
  logic [W-1:0] ref_bits;
  int           ref_x;
  int           exp_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_q <= '0;
    else if (in_vld) cap_q <= in_bits;
  end

  assign ref_bits = OUT_REG ? cap_q : in_bits;

  always_comb begin
    ref_x = 0;
    for (int i = 0; i < SEL_W; i++)
      ref_x = ref_bits[MAN_W+i] ? ref_x + (1 << i) : ref_x - (1 << i);
    exp_sum = int'(ref_bits[W-2:MAN_W]) + ref_x;
  end

  AST_SIGN_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (out_bits[W-1] != ref_bits[W-1]));                     // R1
  AST_MAN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (out_bits[MAN_W-1:0] == ref_bits[MAN_W-1:0]));         // R2
  AST_EXP_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (int'(out_bits[W-2:MAN_W]) == exp_sum));              // R3
  AST_X_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (ref_x[0] && ref_x <= 31 && ref_x >= -31));           // R5

  always_ff @(posedge clk)
    if (!rst_n) AST_RST_IDLE: assert (!out_vld);                      // R7

  generate
    if (OUT_REG) begin : g_seq
      AST_VLD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);                                           // R6
      AST_VLD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);                                         // R6
      AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(out_bits));                                // R9
    end else begin : g_comb
      AST_SAME_CYC: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld == in_vld);                                            // R8
    end
  endgenerate

endmodule

bind fp_negscale fp_negscale_chk #(
  .EXP_W(EXP_W), .MAN_W(MAN_W), .SEL_W(SEL_W), .OUT_REG(OUT_REG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_bits(in_bits),
  .out_vld(out_vld), .out_bits(out_bits)
);

// File: tb/fp_negscale_tb.sv
module fp_negscale_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [63:0] in_bits = '0;
  logic        out_vld, c_vld;
  logic [63:0] out_bits, c_bits;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2.5 clk = ~clk;

  fp_negscale #(.OUT_REG(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_bits(in_bits),
    .out_vld(out_vld), .out_bits(out_bits));

  fp_negscale #(.OUT_REG(1'b0)) u_dut_c (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_bits(in_bits),
    .out_vld(c_vld), .out_bits(c_bits));

  function automatic int digit_x(input logic [63:0] b);
    int x = 0;
    for (int i = 0; i < 5; i++) x += b[52+i] ? (1 << i) : -(1 << i);
    return x;
  endfunction

  function automatic logic [63:0] model(input logic [63:0] b);
    logic [10:0] e;
    e = 11'(int'(b[62:52]) + digit_x(b));
    return {~b[63], e, b[51:0]};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_result(input string tag, input logic [63:0] inp, input logic [63:0] act);
    logic [63:0] e;
    real         want;
    int          x;
    e = model(inp);
    x = digit_x(inp);
    check({tag, " R1 sign"}, {63'd0, act[63]}, {63'd0, e[63]});
    check({tag, " R2 mantissa"}, {12'd0, act[51:0]}, {12'd0, e[51:0]});
    check({tag, " R3 exponent"}, {53'd0, act[62:52]}, {53'd0, e[62:52]});
    want = -$bitstoreal(inp) * (2.0 ** x);
    check({tag, " R4 value"}, $realtobits($bitstoreal(act)), $realtobits(want));
  endtask

  task automatic apply(input logic [63:0] b);
    @(negedge clk);
    in_bits = b;
    in_vld  = 1'b1;
    #1;
    check("R8 comb valid", {63'd0, c_vld}, 64'd1);
    check_result("R8 comb", b, c_bits);
    @(posedge clk);
    #1;
    check("R6 reg valid", {63'd0, out_vld}, 64'd1);
    check_result("R6 reg", b, out_bits);
  endtask

  initial begin
    logic [63:0] held;
    void'($urandom(32'd20240611));
    #1;
    check("R7 reset valid", {63'd0, out_vld}, 64'd0);
    repeat (3) @(negedge clk);
    check("R7 reset valid late", {63'd0, out_vld}, 64'd0);
    rst_n = 1'b1;

    for (int p = 0; p < 32; p++) begin
      int x;
      logic [63:0] b;
      b = {p[0], 11'd1024 | 11'(p), 32'hdead_beef, 20'h0_5a5a};
      x = digit_x(b);
      n_chk++;
      if (!(x[0] && x >= -31 && x <= 31)) begin
        n_bad++;
        $display("FAIL R5: actual %0d expected odd in [-31,31]", x);
      end
      if (p == 0)  check("R5 all-clear is -31", 64'(x), 64'(-31));
      if (p == 31) check("R5 all-set is +31", 64'(x), 64'd31);
      apply(b);
    end

    apply(64'h3ff0_0000_0000_0000);
    apply(64'hbff0_0000_0000_0000);
    apply({1'b0, 11'd32, 52'hf_ffff_ffff_ffff});
    apply({1'b1, 11'd2015, 52'h0});

    for (int k = 0; k < 400; k++) begin
      logic [10:0] e;
      e = 11'(40 + ($urandom % 1960));
      apply({1'($urandom), e, 20'($urandom), 32'($urandom)});
      if (k % 50 == 7) begin
        held = out_bits;
        @(negedge clk);
        in_vld  = 1'b0;
        in_bits = {1'b0, 11'd1000, 52'h1_2345};
        repeat (3) @(negedge clk);
        check("R6 valid low when idle", {63'd0, out_vld}, 64'd0);
        check("R9 hold while idle", out_bits, held);
        check("R8 comb valid low", {63'd0, c_vld}, 64'd0);
      end
    end

    @(negedge clk);
    in_vld = 1'b0;
    @(negedge clk);
    check("R6 valid drops", {63'd0, out_vld}, 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule